// File: doc/BRIEF.md
# Reference-Clock Reset Sequencer with Frequency Qualification

This block decides when the receive section of a line interface may leave reset and when it may start phase acquisition. It watches an asynchronous supply-good level and an active-high external reset. When both allow operation, it first lets a fixed number of reference-clock edges pass, after a two-stage resynchroniser. It then releases the internal reset and measures the reference clock against the nominal line rate picked by a rate selector. Only a measurement that falls inside a tolerance window grants the phase-acquisition enable to the clock-recovery logic.

The frequency is measured in the system clock domain. A free-running Gray-coded counter in the reference domain is synchronised into the system domain. Two snapshots taken a fixed number of system cycles apart are subtracted, and the difference is compared with limits computed from parameters. Measurement never stops after the first qualification. A later reading outside the window withdraws lock and the enable, and the block goes back to measuring without touching the internal reset. An external reset, or loss of supply-good, at any moment starts the whole sequence again.

The system-side time base of the board must keep the external reset high for at least 1 us whenever a stable reference clock cannot be promised at power-up.

Top module: `refclk_rst_seq`

## Requirements
- R1: While `supply_ok` is low or `ext_rst` is high, `core_rst` is 1, `freq_locked` is 0, `phase_acq_en` is 0 and `seq_status` is 0, regardless of either clock.
- R2: Dropping `supply_ok` or raising `ext_rst` at any time asserts `core_rst` at once, without waiting for a clock edge, and clears the warm-up edge count so that a full count repeats on release.
- R3: After the hold is removed, the reference-domain reset is released on the 2nd reference edge. The next 128 reference edges are counted. `core_rst` falls after the 130th reference edge and before the 131st. `seq_status` is 1 while this count runs.
- R4: A measurement counts reference edges over GATE_CYCLES (1024) system cycles. It qualifies when the count N satisfies floor(f*G*(1000-T)/(S*1000)) <= N <= floor(f*G*(1000+T)/(S*1000)), where f is the nominal rate in kHz, G is GATE_CYCLES, S is the system clock in kHz (250000) and T is the tolerance in permille (50, i.e. +/-5%).
- R5: `rate_sel` encodes the nominal rate: 0 = 34368 kHz, 1 = 44736 kHz, 2 = 51840 kHz, 3 = same as 2.
- R6: `seq_status` encodes 0 = held in reset, 1 = counting edges, 2 = frequency check, 3 = frequency locked, 4 = phase acquiring. `core_rst` is 1 exactly in codes 0 and 1. `freq_locked` and `phase_acq_en` are 1 exactly in codes 3 and 4.
- R7: A qualifying measurement ending in code 2 moves the block to code 3 in the following cycle. `freq_locked` and `phase_acq_en` rise together.
- R8: In code 3, `phase_lock_in` high moves the block to code 4 on the next edge. In code 4, `phase_lock_in` low returns it to code 3. In code 2, `phase_lock_in` has no effect.
- R9: A measurement outside the window while in code 3 or 4 returns the block to code 2 in the next cycle, clearing `freq_locked` and `phase_acq_en`. Measurement then repeats back to back.
- R10: Once `core_rst` has fallen, it rises again only through the hold of R2.
- R11: The block enters code 2 in the same cycle that `core_rst` falls, and the first measurement window starts then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Free-running system clock, time base of the measurement |
| ref_clk | input | 1 | Reference clock under qualification |
| supply_ok | input | 1 | Asynchronous supply-good level, high when supply is valid |
| ext_rst | input | 1 | Asynchronous external reset, active high |
| rate_sel | input | 2 | Nominal line rate selector (R5) |
| phase_lock_in | input | 1 | Lock indication from the clock-recovery loop |
| core_rst | output | 1 | Internal reset for the receive section, active high |
| freq_locked | output | 1 | Reference frequency qualified |
| phase_acq_en | output | 1 | Permission for phase acquisition |
| seq_status | output | 3 | Sequence state code (R6) |

## Verification
Assertions check several rules on every cycle. Only a qualifying measurement may raise lock, and a failed one must drop it. The internal reset never returns without a hold, and entry to phase acquiring must follow the lock input. In the reference domain, the warm-up flag must rise on exactly the last counted edge, and the Gray count must change by at most one bit per edge. Other behaviour only the bench scenarios can show. These are the exact number of reference edges between releasing the hold and the fall of the internal reset, and the asynchronous assertion of that reset. They also cover the acceptance and rejection of clocks 3% and 8% away from nominal, and the mapping of each rate selector code to its line rate.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [2:0] {
    ST_HOLD  = 3'd0,
    ST_WARM  = 3'd1,
    ST_FCHK  = 3'd2,
    ST_FLOCK = 3'd3,
    ST_PACQ  = 3'd4
  } seq_state_e;

  // Nominal line rate in kHz for a selector code; code 3 aliases code 2.
  function automatic int unsigned line_rate_khz(input logic [1:0] sel);
    case (sel)
      2'd0:    return 32'd34368;
      2'd1:    return 32'd44736;
      default: return 32'd51840;
    endcase
  endfunction

  // Expected edge count over a gate, scaled by a permille factor, floored.
  function automatic int unsigned window_edge(input int unsigned khz,
                                              input int unsigned gate_cycles,
                                              input int unsigned sys_khz,
                                              input int unsigned scale_permille);
    longint unsigned num;
    longint unsigned den;
    num = 64'(khz) * 64'(gate_cycles) * 64'(scale_permille);
    den = 64'(sys_khz) * 64'd1000;
    return 32'(num / den);
  endfunction

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shreg <= '0;
    else         shreg <= {shreg[STAGES-2:0], d};
  end

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/rsq_ref_warmup.sv
module rsq_ref_warmup #(
  parameter int WARM_EDGES = 128,
  parameter int CNT_W      = 9
) (
  input  logic             ref_clk,
  input  logic             ref_rst_n,
  output logic             warm_done,
  output logic [CNT_W-1:0] ref_gray
);
  localparam int WARM_W = $clog2(WARM_EDGES + 1);

  logic [WARM_W-1:0] wcnt;
  logic [CNT_W-1:0]  ref_bin;

  // Warm-up counter: stops once the last edge has been counted.
  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      wcnt      <= '0;
      warm_done <= 1'b0;
    end else if (!warm_done) begin
      wcnt      <= wcnt + 1'b1;
      warm_done <= (wcnt == WARM_W'(WARM_EDGES - 1));
    end
  end

  // Free-running edge counter, published as registered Gray code.
  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      ref_bin  <= '0;
      ref_gray <= '0;
    end else begin
      ref_bin  <= ref_bin + 1'b1;
      ref_gray <= ref_bin ^ (ref_bin >> 1);
    end
  end

  // R3: the flag rises exactly on the last counted edge
  a_r3_done_exact: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $rose(warm_done) |-> $past(wcnt) == WARM_W'(WARM_EDGES - 1));

  // R3: the counter never runs past the programmed edge count
  a_r3_cnt_limit: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    wcnt <= WARM_W'(WARM_EDGES));

  // R4: the crossing count changes by at most one bit per edge
  a_r4_gray_step: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $countones(ref_gray ^ $past(ref_gray)) <= 1);
endmodule

// File: rtl/rsq_freq_meter.sv
module rsq_freq_meter
  import rsq_pkg::*;
#(
  parameter int CNT_W        = 9,
  parameter int GATE_CYCLES  = 1024,
  parameter int SYS_CLK_KHZ  = 250000,
  parameter int TOL_PERMILLE = 50,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] ref_gray,
  input  logic             run,
  input  logic [1:0]       rate_sel,
  output logic             gate_end,
  output logic             in_window
);
  localparam int GATE_W = $clog2(GATE_CYCLES);

  logic [CNT_W-1:0]  gsync [SYNC_STAGES];
  logic [CNT_W-1:0]  ref_bin;
  logic [CNT_W-1:0]  snap;
  logic [CNT_W-1:0]  meas;
  logic [GATE_W-1:0] gcnt;
  logic [CNT_W-1:0]  lo_tab [4];
  logic [CNT_W-1:0]  hi_tab [4];

  function automatic logic [CNT_W-1:0] gray_to_bin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Window limits for every selector code.
  for (genvar s = 0; s < 4; s++) begin : g_limits
    assign lo_tab[s] = CNT_W'(window_edge(line_rate_khz(2'(s)), GATE_CYCLES,
                                          SYS_CLK_KHZ, 1000 - TOL_PERMILLE));
    assign hi_tab[s] = CNT_W'(window_edge(line_rate_khz(2'(s)), GATE_CYCLES,
                                          SYS_CLK_KHZ, 1000 + TOL_PERMILLE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) gsync[k] <= '0;
    end else begin
      gsync[0] <= ref_gray;
      for (int k = 1; k < SYNC_STAGES; k++) gsync[k] <= gsync[k-1];
    end
  end

  assign ref_bin = gray_to_bin(gsync[SYNC_STAGES-1]);

  // Gate timer and snapshot difference.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcnt     <= '0;
      snap     <= '0;
      meas     <= '0;
      gate_end <= 1'b0;
    end else begin
      gate_end <= 1'b0;
      if (!run) begin
        gcnt <= '0;
        snap <= ref_bin;
      end else if (gcnt == GATE_W'(GATE_CYCLES - 1)) begin
        gcnt     <= '0;
        snap     <= ref_bin;
        meas     <= ref_bin - snap;
        gate_end <= 1'b1;
      end else begin
        gcnt <= gcnt + 1'b1;
      end
    end
  end

  assign in_window = (meas >= lo_tab[rate_sel]) && (meas <= hi_tab[rate_sel]);

  // R4: a gate result is a single-cycle event
  a_r4_gate_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    gate_end |=> !gate_end);

  // R9: results only appear while a measurement is running
  a_r9_gate_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    gate_end |-> $past(run));
endmodule

// File: rtl/refclk_rst_seq.sv
module refclk_rst_seq
  import rsq_pkg::*;
#(
  parameter int SYS_CLK_KHZ  = 250000,
  parameter int GATE_CYCLES  = 1024,
  parameter int TOL_PERMILLE = 50,
  parameter int WARM_EDGES   = 128,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       sys_clk,
  input  logic       ref_clk,
  input  logic       supply_ok,
  input  logic       ext_rst,
  input  logic [1:0] rate_sel,
  input  logic       phase_lock_in,
  output logic       core_rst,
  output logic       freq_locked,
  output logic       phase_acq_en,
  output logic [2:0] seq_status
);
  localparam int HI_MAX = int'(window_edge(32'd51840, GATE_CYCLES, SYS_CLK_KHZ,
                                           1000 + TOL_PERMILLE));
  localparam int CNT_W  = $clog2(2 * HI_MAX + 2);

  logic             hold_n;
  logic             ref_rst_n;
  logic             sys_rst_n;
  logic             warm_done;
  logic             warm_sync;
  logic [CNT_W-1:0] ref_gray;
  logic             run;
  logic             gate_end;
  logic             in_win;
  seq_state_e       state, state_nx;

  assign hold_n = supply_ok & ~ext_rst;

  rsq_sync #(.STAGES(SYNC_STAGES)) i_ref_rst (
    .clk(ref_clk), .arst_n(hold_n), .d(1'b1), .q(ref_rst_n));

  rsq_sync #(.STAGES(SYNC_STAGES)) i_sys_rst (
    .clk(sys_clk), .arst_n(hold_n), .d(1'b1), .q(sys_rst_n));

  rsq_ref_warmup #(.WARM_EDGES(WARM_EDGES), .CNT_W(CNT_W)) i_warm (
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
    .warm_done(warm_done), .ref_gray(ref_gray));

  rsq_sync #(.STAGES(SYNC_STAGES)) i_warm_sync (
    .clk(sys_clk), .arst_n(sys_rst_n), .d(warm_done), .q(warm_sync));

  assign run = (state == ST_FCHK) || (state == ST_FLOCK) || (state == ST_PACQ);

  rsq_freq_meter #(
    .CNT_W(CNT_W), .GATE_CYCLES(GATE_CYCLES), .SYS_CLK_KHZ(SYS_CLK_KHZ),
    .TOL_PERMILLE(TOL_PERMILLE), .SYNC_STAGES(SYNC_STAGES)
  ) i_meter (
    .clk(sys_clk), .rst_n(sys_rst_n), .ref_gray(ref_gray), .run(run),
    .rate_sel(rate_sel), .gate_end(gate_end), .in_window(in_win));

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_HOLD:  state_nx = ST_WARM;
      ST_WARM:  if (warm_sync) state_nx = ST_FCHK;
      ST_FCHK:  if (gate_end && in_win) state_nx = ST_FLOCK;
      ST_FLOCK: if (gate_end && !in_win) state_nx = ST_FCHK;
                else if (phase_lock_in)  state_nx = ST_PACQ;
      ST_PACQ:  if (gate_end && !in_win) state_nx = ST_FCHK;
                else if (!phase_lock_in) state_nx = ST_FLOCK;
      default:  state_nx = ST_HOLD;
    endcase
  end

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) state <= ST_HOLD;
    else            state <= state_nx;
  end

  assign core_rst     = (state == ST_HOLD) || (state == ST_WARM);
  assign freq_locked  = (state == ST_FLOCK) || (state == ST_PACQ);
  assign phase_acq_en = freq_locked;
  assign seq_status   = 3'(state);

  // R10: the internal reset stays released until a hold arrives
  a_r10_no_reassert: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !core_rst |=> !core_rst);

  // R11: reset release follows the synchronised warm-up flag
  a_r11_release_after_warm: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $fell(core_rst) |-> $past(warm_sync));

  // R7: lock is granted only on a qualifying gate result
  a_r7_lock_needs_window: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $rose(freq_locked) |-> $past(gate_end && in_win));

  // R9: a failed measurement withdraws lock and the enable
  a_r9_miss_drops_lock: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (gate_end && !in_win) |=> (!freq_locked && !phase_acq_en && !core_rst));

  // R8: phase acquiring is entered only with the recovery lock input high
  a_r8_acq_follows_input: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (seq_status == 3'd4 && $past(seq_status) == 3'd3) |-> $past(phase_lock_in));

  // R6: only defined status codes appear
  a_r6_status_legal: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    seq_status <= 3'd4);
endmodule

// File: tb/test_refclk_rst_seq.sv
`timescale 1ns/1ps
module test_refclk_rst_seq;
  localparam int GATE = 1024;

  logic       sys_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       supply_ok = 1'b0;
  logic       ext_rst = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic       phase_lock_in = 1'b0;
  logic       core_rst, freq_locked, phase_acq_en;
  logic [2:0] seq_status;

  int  checks = 0;
  int  fails  = 0;
  int  ref_edges = 0;
  real ref_half = 14.548;
  bit  model_on = 0;
  bit  finished = 0;
  int  prev_st = 0;
  int  hold_age = 0;

  refclk_rst_seq i_refclk_rst_seq (
    .sys_clk(sys_clk), .ref_clk(ref_clk), .supply_ok(supply_ok), .ext_rst(ext_rst),
    .rate_sel(rate_sel), .phase_lock_in(phase_lock_in), .core_rst(core_rst),
    .freq_locked(freq_locked), .phase_acq_en(phase_acq_en), .seq_status(seq_status));

  always #2 sys_clk = ~sys_clk;
  initial forever #(ref_half) ref_clk = ~ref_clk;
  always @(posedge ref_clk) ref_edges++;

  task automatic set_ref(input real khz);
    ref_half = 500000.0 / khz;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge sys_clk);
  endtask

  task automatic wait_status(input int exp, input int limit, output bit hit);
    hit = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge sys_clk);
      if (int'(seq_status) == exp) begin hit = 1; break; end
    end
  endtask

  // Returns 1 if the status ever equals 'bad' within n cycles.
  task automatic watch_absent(input int bad, input int n, output bit seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge sys_clk);
      if (int'(seq_status) == bad) seen = 1;
    end
  endtask

  task automatic release_hold(input string req);
    bit done;
    @(negedge sys_clk); #1;
    ref_edges = 0;
    supply_ok = 1'b1;
    ext_rst   = 1'b0;
    done = 0;
    for (int i = 0; i < 3000 && !done; i++) begin
      @(negedge sys_clk);
      if (core_rst == 1'b0) done = 1;
      else if (i > 4) chk(int'(seq_status) == 1, "R3", "status while counting", int'(seq_status), 1);
    end
    chk(ref_edges == 130, req, "ref edges before reset release", ref_edges, 130);
    chk(int'(seq_status) == 2, "R11", "status at reset release", int'(seq_status), 2);
  endtask

  // Per-cycle behavioural model of the status sequence and output decode.
  always @(negedge sys_clk) begin
    if (model_on) begin
      bit hold;
      bit ok;
      int st;
      hold = !supply_ok || ext_rst;
      st = int'(seq_status);
      ok = (core_rst == (st <= 1)) && (freq_locked == (st >= 3)) &&
           (phase_acq_en == (st >= 3)) && (st <= 4);
      if (hold && st != 0) ok = 0;
      if (!(st == 0 && (hold || hold_age <= 3))) begin
        case (prev_st)
          0: if (!(st == 0 || st == 1)) ok = 0;
          1: if (!(st == 1 || st == 2)) ok = 0;
          2: if (!(st == 2 || st == 3)) ok = 0;
          3: begin
               if (!(st == 2 || st == 3 || st == 4)) ok = 0;
               if (st == 4 && !phase_lock_in) ok = 0;
               if (st == 3 && phase_lock_in) ok = 0;
             end
          4: begin
               if (!(st == 2 || st == 3 || st == 4)) ok = 0;
               if (st == 3 && phase_lock_in) ok = 0;
               if (st == 4 && !phase_lock_in) ok = 0;
             end
          default: ok = 0;
        endcase
      end
      chk(ok, "R6 R10", "per-cycle model status", st, prev_st);
      prev_st = st;
      if (hold) hold_age = 0;
      else if (hold_age < 100) hold_age++;
    end
  end

  initial begin
    #(4.0 * 190000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit hit;
    bit seen;
    set_ref(34368.0);
    step(10);
    model_on = 1;
    prev_st  = int'(seq_status);
    // R1: reset state
    chk(core_rst == 1'b1, "R1", "core_rst in hold", int'(core_rst), 1);
    chk(int'(seq_status) == 0, "R1", "status in hold", int'(seq_status), 0);
    chk(freq_locked == 1'b0 && phase_acq_en == 1'b0, "R1", "flags in hold",
        int'(freq_locked), 0);
    step(300);
    chk(int'(seq_status) == 0, "R1", "status after long hold", int'(seq_status), 0);

    // R3: warm-up edge count
    release_hold("R3");

    // R7 R5: E3 nominal qualifies
    wait_status(3, 3 * GATE + 20, hit);
    chk(hit, "R7", "lock on E3 nominal", int'(seq_status), 3);
    chk(freq_locked && phase_acq_en, "R7", "flags after lock", int'(phase_acq_en), 1);

    // R8: phase acquisition follows the lock input
    @(negedge sys_clk); #1 phase_lock_in = 1'b1;
    step(2);
    chk(int'(seq_status) == 4, "R8", "enter phase acquiring", int'(seq_status), 4);
    @(negedge sys_clk); #1 phase_lock_in = 1'b0;
    step(2);
    chk(int'(seq_status) == 3, "R8", "back to freq locked", int'(seq_status), 3);

    // R9 R5: DS3 window rejects an E3 clock
    @(negedge sys_clk); #1 rate_sel = 2'd1;
    wait_status(2, 2 * GATE + 20, hit);
    chk(hit, "R9", "lock withdrawn on miss", int'(seq_status), 2);
    chk(core_rst == 1'b0, "R10", "reset stays low after miss", int'(core_rst), 0);
    @(negedge sys_clk); #1 phase_lock_in = 1'b1;
    watch_absent(3, 3 * GATE, seen);
    chk(!seen, "R5", "DS3 window rejects E3 clock", int'(seen), 0);
    chk(int'(seq_status) == 2 && !phase_acq_en, "R8", "lock input ignored in check",
        int'(seq_status), 2);
    @(negedge sys_clk); #1 phase_lock_in = 1'b0;

    // R5: DS3 clock with DS3 selection
    set_ref(44736.0);
    wait_status(3, 3 * GATE + 20, hit);
    chk(hit, "R5", "lock on DS3 nominal", int'(seq_status), 3);

    // R2: external reset asynchronously restarts the sequence
    @(negedge sys_clk); #1 ext_rst = 1'b1;
    #1;
    chk(core_rst == 1'b1, "R2", "immediate reset on ext_rst", int'(core_rst), 1);
    step(50);
    chk(int'(seq_status) == 0, "R2", "status held on ext_rst", int'(seq_status), 0);
    release_hold("R2");
    wait_status(3, 3 * GATE + 20, hit);
    chk(hit, "R11", "relock after restart", int'(seq_status), 3);

    // R5: STS-1 and the alias code
    set_ref(51840.0);
    @(negedge sys_clk); #1 rate_sel = 2'd2;
    wait_status(3, 4 * GATE + 20, hit);
    if (hit) watch_absent(2, 2 * GATE, seen); else seen = 1;
    chk(hit && !seen, "R5", "STS-1 nominal holds lock", int'(seq_status), 3);
    @(negedge sys_clk); #1 rate_sel = 2'd3;
    watch_absent(2, 3 * GATE, seen);
    chk(!seen, "R5", "code 3 aliases code 2", int'(seen), 0);

    // R4: tolerance window boundaries
    @(negedge sys_clk); #1 rate_sel = 2'd0;
    set_ref(34368.0 * 1.08);
    wait_status(2, 3 * GATE + 20, hit);
    chk(hit, "R4", "fall to check on wrong rate", int'(seq_status), 2);
    watch_absent(3, 3 * GATE, seen);
    chk(!seen, "R4", "+8% rejected", int'(seen), 0);
    set_ref(34368.0 * 0.92);
    watch_absent(3, 3 * GATE, seen);
    chk(!seen, "R4", "-8% rejected", int'(seen), 0);
    set_ref(34368.0 * 1.03);
    wait_status(3, 3 * GATE + 20, hit);
    chk(hit, "R4", "+3% accepted", int'(seq_status), 3);
    set_ref(34368.0 * 0.97);
    watch_absent(2, 3 * GATE, seen);
    chk(!seen, "R4", "-3% keeps lock", int'(seen), 0);

    // R2 R1: supply loss
    @(negedge sys_clk); #1 supply_ok = 1'b0;
    #1;
    chk(core_rst == 1'b1 && !freq_locked && !phase_acq_en, "R2", "immediate reset on supply loss",
        int'(core_rst), 1);
    step(20);
    chk(int'(seq_status) == 0, "R1", "status with supply low", int'(seq_status), 0);
    release_hold("R2");
    wait_status(3, 3 * GATE + 20, hit);
    chk(hit, "R7", "lock after supply return", int'(seq_status), 3);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule